// File: doc/BRIEF.md
# Quadrant-1 compressed instruction expander

This stage turns a 16-bit compressed parcel from the quadrant whose low two bits are `01` into the equivalent 32-bit base instruction. It handles five compressed forms: add-immediate-word, jump-and-link, load-upper-immediate, stack-pointer adjust by a multiple of sixteen, and logical right shift by an immediate. The parcel comes with a valid strobe and a bit that selects 64-bit or 32-bit decoding. One registered cycle later the block presents a valid strobe, the expanded word and a flag that marks encodings that are reserved, fail a legality guard, or fall outside the subset.

The major opcode `001` has two meanings. Under 64-bit decoding it is add-immediate-word; under 32-bit decoding it is jump-and-link with the return address register. An elaboration parameter can remove 64-bit support altogether. The front end of a fetch path places the block after parcel alignment and passes the expanded word on to the full-width decoder.

Top module: `cx_expand_q1`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_illegal` are low and `out_word` is zero after that edge.
- R2: `out_valid` at each edge equals `in_valid` one edge earlier. A cycle without `in_valid` leaves `out_word` and `out_illegal` unchanged.
- R3: Whenever `out_illegal` is high with `out_valid`, `out_word` is all zeros.
- R4: With 64-bit decoding, opcode `001` (bit 12 = imm[5], bits 11:7 = rd, bits 6:2 = imm[4:0]) expands to ADDIW rd, rd, sign-extended imm: opcode `0011011`, funct3 `000`.
- R5: With 64-bit decoding, opcode `001` with rd = 0 is illegal.
- R6: With 32-bit decoding, opcode `001` expands to JAL with rd = 1. The offset bits in the parcel are imm[11] = bit 12, imm[4] = bit 11, imm[9:8] = bits 10:9, imm[10] = bit 8, imm[6] = bit 7, imm[7] = bit 6, imm[3:1] = bits 5:3 and imm[5] = bit 2, with imm[0] = 0 and sign extension from imm[11]. The result is always legal.
- R7: Opcode `011` with rd (bits 11:7) other than 0 and 2 expands to LUI rd with the 20-bit upper immediate formed by sign-extending {bit 12, bits 6:2}.
- R8: Opcode `011` with rd = 0, or with rd not 2 and {bit 12, bits 6:2} = 0, is illegal.
- R9: Opcode `011` with rd = 2 expands to ADDI x2, x2, imm with imm[9] = bit 12, imm[4] = bit 6, imm[6] = bit 5, imm[8:7] = bits 4:3, imm[5] = bit 2, imm[3:0] = 0, sign-extended. It is illegal when those six bits are all zero.
- R10: Opcode `100` with bits 11:10 = `00` expands to SRLI r, r, shamt. Here r = 8 + bits 9:7 and shamt = {bit 12, bits 6:2}.
- R11: That shift with bit 12 set is illegal under 32-bit decoding.
- R12: Every other parcel is illegal. This covers low bits other than `01`, opcodes `000`, `010`, `101`, `110` and `111`, and opcode `100` with bits 11:10 not `00`.
- R13: With parameter `HAS_RV64 = 0`, `in_rv64` has no effect and opcode `001` always decodes as JAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Parcel present this cycle |
| in_inst | input | 16 | Compressed parcel |
| in_rv64 | input | 1 | 1 = 64-bit decoding, 0 = 32-bit decoding |
| out_valid | output | 1 | Registered valid |
| out_word | output | 32 | Expanded instruction, zero when illegal |
| out_illegal | output | 1 | Parcel reserved, constrained or unsupported |

## Verification
The bench instantiates the block twice on the same stimulus. One copy uses the default `HAS_RV64 = 1`. The other uses `HAS_RV64 = 0`, so each parcel sent with `in_rv64` high also shows that the mode bit is ignored when 64-bit support is removed. Every payload of opcodes `001`, `011` and `100` is swept under both decoding modes. That sweep reaches every rd = 0 and rd = 2 guard, every zero immediate and every reserved shift amount.

// File: rtl/cx_pkg.sv
package cx_pkg;
   localparam int PARCEL_W = 16;
   localparam int WORD_W   = 32;

   localparam logic [1:0] QUAD_ONE  = 2'b01;
   localparam logic [2:0] OP_WIMM   = 3'b001;
   localparam logic [2:0] OP_UPPER  = 3'b011;
   localparam logic [2:0] OP_ALU    = 3'b100;

   localparam logic [6:0] BASE_JAL  = 7'b1101111;
   localparam logic [6:0] BASE_IMMW = 7'b0011011;
   localparam logic [6:0] BASE_LUI  = 7'b0110111;
   localparam logic [6:0] BASE_IMM  = 7'b0010011;

   localparam logic [4:0] REG_ZERO  = 5'd0;
   localparam logic [4:0] REG_LINK  = 5'd1;
   localparam logic [4:0] REG_STACK = 5'd2;

   typedef enum logic [2:0] {
      FORM_NONE,
      FORM_JAL,
      FORM_ADDIW,
      FORM_LUI,
      FORM_SPADJ,
      FORM_SRLI
   } form_e;
endpackage

// File: rtl/cx_classify.sv
module cx_classify
   import cx_pkg::*;
#(
   parameter int PW = PARCEL_W
) (
   input  logic [PW-1:0] inst,
   input  logic          wide,
   output form_e         form,
   output logic          legal
);
   localparam int RD_HI = 11;
   localparam int RD_LO = 7;

   logic [2:0] major;
   logic [1:0] quad;
   logic [4:0] rd;
   logic       imm_nz;

   assign major  = inst[PW-1 -: 3];
   assign quad   = inst[1:0];
   assign rd     = inst[RD_HI:RD_LO];
   assign imm_nz = inst[12] | (|inst[6:2]);

   always_comb begin
      form  = FORM_NONE;
      legal = 1'b0;
      if (quad == QUAD_ONE) begin
         unique case (major)
            OP_WIMM: begin
               if (wide) begin
                  form  = FORM_ADDIW;
                  legal = (rd != REG_ZERO);
               end else begin
                  form  = FORM_JAL;
                  legal = 1'b1;
               end
            end
            OP_UPPER: begin
               if (rd == REG_STACK) begin
                  form  = FORM_SPADJ;
                  legal = imm_nz;
               end else begin
                  form  = FORM_LUI;
                  legal = imm_nz && (rd != REG_ZERO);
               end
            end
            OP_ALU: begin
               if (rd[4:3] == 2'b00) begin
                  form  = FORM_SRLI;
                  legal = wide | ~inst[12];
               end
            end
            default: begin
               form  = FORM_NONE;
               legal = 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/cx_assemble.sv
module cx_assemble
   import cx_pkg::*;
#(
   parameter int WW = WORD_W
) (
   input  logic [12:2]   pay,
   input  form_e         form,
   output logic [WW-1:0] word
);
   logic [4:0]  rd;
   logic [4:0]  crd;
   logic [5:0]  imm6;
   logic [10:0] joff;
   logic [5:0]  sp6;
   logic [11:0] sp12;

   assign rd   = pay[11:7];
   assign crd  = {2'b01, pay[9:7]};
   assign imm6 = {pay[12], pay[6:2]};
   // jump offset bits 11 down to 1
   assign joff = {pay[12], pay[8], pay[10], pay[9], pay[6], pay[7],
                  pay[2], pay[11], pay[5], pay[4], pay[3]};
   // stack adjust offset bits 9 down to 4
   assign sp6  = {pay[12], pay[4], pay[3], pay[5], pay[2], pay[6]};
   assign sp12 = {{2{sp6[5]}}, sp6, 4'b0000};

   always_comb begin
      unique case (form)
         FORM_JAL:
            word = {joff[10], joff[9:0], joff[10], {8{joff[10]}},
                    REG_LINK, BASE_JAL};
         FORM_ADDIW:
            word = {{6{imm6[5]}}, imm6, rd, 3'b000, rd, BASE_IMMW};
         FORM_LUI:
            word = {{14{imm6[5]}}, imm6, rd, BASE_LUI};
         FORM_SPADJ:
            word = {sp12, REG_STACK, 3'b000, REG_STACK, BASE_IMM};
         FORM_SRLI:
            word = {6'b000000, imm6, crd, 3'b101, crd, BASE_IMM};
         default:
            word = '0;
      endcase
   end
endmodule

// File: rtl/cx_expand_q1.sv
module cx_expand_q1
   import cx_pkg::*;
#(
   parameter int PARCEL_BITS = PARCEL_W,
   parameter int WORD_BITS   = WORD_W,
   parameter bit HAS_RV64    = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [PARCEL_BITS-1:0] in_inst,
   input  logic                   in_rv64,
   output logic                   out_valid,
   output logic [WORD_BITS-1:0]   out_word,
   output logic                   out_illegal
);
   if (PARCEL_BITS != PARCEL_W) begin : g_bad_parcel
      $error("cx_expand_q1: parcel width must be 16");
   end
   if (WORD_BITS != WORD_W) begin : g_bad_word
      $error("cx_expand_q1: word width must be 32");
   end

   logic                 wide;
   form_e                form;
   logic                 legal;
   logic [WORD_BITS-1:0] built;

   if (HAS_RV64) begin : g_mode_sel
      assign wide = in_rv64;
   end else begin : g_mode_fixed
      logic unused_rv64;
      assign unused_rv64 = in_rv64;
      assign wide = 1'b0;
   end

   cx_classify #(.PW(PARCEL_BITS)) u_cls (
      .inst  (in_inst),
      .wide  (wide),
      .form  (form),
      .legal (legal)
   );

   cx_assemble #(.WW(WORD_BITS)) u_asm (
      .pay  (in_inst[12:2]),
      .form (form),
      .word (built)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_word    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_illegal <= ~legal;
            out_word    <= legal ? built : '0;
         end
      end
   end
endmodule

// File: rtl/cx_expand_q1_chk.sv
module cx_expand_q1_chk #(
   parameter bit HAS_RV64 = 1'b1
) (
   input logic        clk,
   input logic        rst,
   input logic        in_valid,
   input logic [2:0]  op,
   input logic [1:0]  quad,
   input logic [4:0]  rd,
   input logic [5:0]  imm6,
   input logic        in_rv64,
   input logic        out_valid,
   input logic [31:0] out_word,
   input logic        out_illegal
);
   logic mode64;
   assign mode64 = HAS_RV64 && in_rv64;

   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && !out_illegal && out_word == 32'h0));

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_illegal)));

   assert_illegal_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_illegal) |-> out_word == 32'h0);

   assert_addiw_x0_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && quad == 2'b01 && op == 3'b001 && mode64 && rd == 5'd0)
      |=> out_illegal);

   assert_jal_link_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && quad == 2'b01 && op == 3'b001 && !mode64)
      |=> (!out_illegal && out_word[11:0] == 12'h0EF));

   assert_lui_guard_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && quad == 2'b01 && op == 3'b011 &&
       (rd == 5'd0 || (rd != 5'd2 && imm6 == 6'd0)))
      |=> out_illegal);

   assert_srli_regs_R10: assert property (@(posedge clk) disable iff (rst)
      (in_valid && quad == 2'b01 && op == 3'b100 && rd[4:3] == 2'b00 &&
       (mode64 || !imm6[5]))
      |=> (!out_illegal && out_word[11:10] == 2'b01 && out_word[19:18] == 2'b01));

   assert_other_quad_R12: assert property (@(posedge clk) disable iff (rst)
      (in_valid && quad != 2'b01) |=> out_illegal);
endmodule

bind cx_expand_q1 cx_expand_q1_chk #(.HAS_RV64(HAS_RV64)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .op          (in_inst[15:13]),
   .quad        (in_inst[1:0]),
   .rd          (in_inst[11:7]),
   .imm6        ({in_inst[12], in_inst[6:2]}),
   .in_rv64     (in_rv64),
   .out_valid   (out_valid),
   .out_word    (out_word),
   .out_illegal (out_illegal)
);

// File: tb/cx_expand_q1_test.sv
module cx_expand_q1_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_inst = 16'h0;
   logic        in_rv64 = 1'b0;
   logic        ov, oi, ov32, oi32;
   logic [31:0] ow, ow32;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct packed {
      logic [31:0] w;
      logic        ill;
      logic [31:0] w32;
      logic        ill32;
      logic [7:0]  req;
      logic [15:0] inst;
   } item_t;
   item_t sbq[$];

   always #2 clk = ~clk;

   cx_expand_q1 uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_inst(in_inst),
      .in_rv64(in_rv64), .out_valid(ov), .out_word(ow), .out_illegal(oi));

   cx_expand_q1 #(.HAS_RV64(1'b0)) uut_rv32only (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_inst(in_inst),
      .in_rv64(in_rv64), .out_valid(ov32), .out_word(ow32), .out_illegal(oi32));

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // Expected result from the requirement text; req tells which rule applies.
   function automatic void model(input logic [15:0] c, input bit m64,
                                 output logic ill, output logic [31:0] w,
                                 output logic [7:0] req);
      logic [4:0]  r;
      logic [5:0]  k;
      logic [20:0] off;
      logic [11:0] ad;
      r   = c[11:7];
      k   = {c[12], c[6:2]};
      ill = 1'b1;
      w   = 32'h0;
      req = 8'd12;
      if (c[1:0] == 2'b01 && c[15:13] == 3'b001 && m64) begin
         req = (r == 0) ? 8'd5 : 8'd4;
         if (r != 0) begin
            ill = 1'b0;
            w = {{6{k[5]}}, k, r, 3'd0, r, 7'h1B};
         end
      end else if (c[1:0] == 2'b01 && c[15:13] == 3'b001) begin
         req = 8'd6;
         off = 21'h0;
         off[11] = c[12]; off[4] = c[11]; off[9:8] = c[10:9]; off[10] = c[8];
         off[6] = c[7]; off[7] = c[6]; off[3:1] = c[5:3]; off[5] = c[2];
         off[20:12] = {9{c[12]}};
         ill = 1'b0;
         w = {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'h6F};
      end else if (c[1:0] == 2'b01 && c[15:13] == 3'b011 && r == 2) begin
         req = 8'd9;
         ad = 12'h0;
         ad[9] = c[12]; ad[4] = c[6]; ad[6] = c[5]; ad[8:7] = c[4:3]; ad[5] = c[2];
         ad[11:10] = {2{c[12]}};
         if (k != 0) begin
            ill = 1'b0;
            w = {ad, 5'd2, 3'd0, 5'd2, 7'h13};
         end
      end else if (c[1:0] == 2'b01 && c[15:13] == 3'b011) begin
         req = (r == 0 || k == 0) ? 8'd8 : 8'd7;
         if (r != 0 && k != 0) begin
            ill = 1'b0;
            w = {{14{k[5]}}, k, r, 7'h37};
         end
      end else if (c[1:0] == 2'b01 && c[15:13] == 3'b100 && c[11:10] == 2'b00) begin
         req = (!m64 && c[12]) ? 8'd11 : 8'd10;
         if (m64 || !c[12]) begin
            ill = 1'b0;
            w = {6'd0, k, 2'b01, c[9:7], 3'd5, 2'b01, c[9:7], 7'h13};
         end
      end
   endfunction

   // Driver: one parcel per call, expected results pushed to the scoreboard.
   task automatic send(input logic [15:0] c, input bit m64);
      item_t it;
      logic [7:0] rq;
      @(negedge clk);
      in_valid = 1'b1;
      in_inst  = c;
      in_rv64  = m64;
      model(c, m64, it.ill, it.w, it.req);
      model(c, 1'b0, it.ill32, it.w32, rq);   // R13: fixed 32-bit copy
      it.inst = c;
      sbq.push_back(it);
   endtask

   // Directed parcel with a hand-computed expected word for the default copy.
   task automatic send_fixed(input logic [15:0] c, input bit m64,
                             input logic exp_ill, input logic [31:0] exp_w,
                             input string req);
      send(c, m64);
      @(posedge clk);
      #1;
      check(oi == exp_ill && ow == exp_w, req, ow, exp_w);
   endtask

   // Monitor: compares both copies against the oldest expected item.
   always @(negedge clk) begin
      if (!rst && ov) begin
         if (sbq.size() == 0) begin
            check(1'b0, "R2 unexpected valid", ow, 32'h0);
         end else begin
            item_t it;
            string rs;
            it = sbq.pop_front();
            rs = $sformatf("R%0d inst=%04h", it.req, it.inst);
            check(oi == it.ill && ow == it.w, rs, {31'h0, oi} ^ ow, it.w);
            check(ov32 && oi32 == it.ill32 && ow32 == it.w32,
                  {"R13 ", rs}, ow32, it.w32);
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 32'h0, 32'h0);
         finish_run();
      end
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(posedge clk);
      #1;
      check(!ov && !oi && ow == 32'h0, "R1 reset state", ow, 32'h0);
      @(negedge clk);
      rst = 1'b0;

      send_fixed(16'h357D, 1'b1, 1'b0, 32'hFFF5051B, "R4 addiw x10,-1");
      send_fixed(16'h2005, 1'b1, 1'b1, 32'h0,        "R5 addiw x0");
      send_fixed(16'h2005, 1'b0, 1'b0, 32'h020000EF, "R6 jal +32");
      send_fixed(16'h6085, 1'b0, 1'b0, 32'h000010B7, "R7 lui x1,1");
      send_fixed(16'h6081, 1'b1, 1'b1, 32'h0,        "R8 lui zero imm");
      send_fixed(16'h6005, 1'b1, 1'b1, 32'h0,        "R8 lui x0");
      send_fixed(16'h6141, 1'b0, 1'b0, 32'h01010113, "R9 sp adjust 16");
      send_fixed(16'h6101, 1'b0, 1'b1, 32'h0,        "R9 sp adjust zero");
      send_fixed(16'h8005, 1'b0, 1'b0, 32'h00145413, "R10 srli x8,1");
      send_fixed(16'h9005, 1'b1, 1'b0, 32'h02145413, "R10 srli x8,33");
      send_fixed(16'h9005, 1'b0, 1'b1, 32'h0,        "R11 srli shamt5 rv32");
      send_fixed(16'h0001, 1'b0, 1'b1, 32'h0,        "R12 opcode 000");
      send_fixed(16'h8405, 1'b1, 1'b1, 32'h0,        "R12 opcode 100 funct 01");
      send_fixed(16'h357E, 1'b1, 1'b1, 32'h0,        "R12 quadrant 2");
      send_fixed(16'h2005, 1'b1, 1'b1, 32'h0,        "R3 illegal after legal");

      // R2: idle cycles hold word and flag
      send_fixed(16'h6085, 1'b0, 1'b0, 32'h000010B7, "R2 load before idle");
      @(negedge clk);
      in_valid = 1'b0;
      in_inst  = 16'h2005;
      in_rv64  = 1'b1;
      held = ow;
      repeat (3) @(posedge clk);
      #1;
      check(!ov && !oi && ow == held, "R2 idle hold", ow, held);

      // sweep all payloads of the covered opcodes in both modes
      for (int op = 0; op < 3; op++) begin
         for (int p = 0; p < 2048; p++) begin
            logic [2:0] mj;
            mj = (op == 0) ? 3'b001 : (op == 1) ? 3'b011 : 3'b100;
            send({mj, p[10:0], 2'b01}, 1'b1);
            send({mj, p[10:0], 2'b01}, 1'b0);
         end
      end
      send(16'h4505, 1'b1);   // R12 opcode 010
      send(16'hE005, 1'b0);   // R12 opcode 111
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(sbq.size() == 0, "R2 scoreboard drained", sbq.size(), 32'h0);
      finish_run();
   end
endmodule